// File: doc/BRIEF.md
# Motion-Gated Temporal Pixel Filter

This block smooths residual noise along the time axis of a video stream that has already been cleaned spatially. On each accepted cycle it takes two 8-bit luma samples from the same screen position: one from the field being produced now and one from the field before it. If the two samples are close, the pixel is judged static and the block emits a fixed 0.6/0.4 fixed-point blend that favours the current field. If they differ by the threshold or more, the pixel is judged to be moving and the current sample passes through untouched, so that moving edges do not smear.

The threshold is a plain 8-bit input, sampled together with each pixel pair, so a controller can retune it between fields or pixels. Results leave through a two-register pipeline with a matching valid flag. Between valid results the output holds its last value.

Top module: `temporal_motion_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and out_pix is 0.
- R2: out_valid is high exactly two rising clock edges after the edge that samples in_valid high, and low two edges after an edge that samples it low.
- R3: When |cur_pix − prev_pix| is strictly less than thresh, out_pix equals (154·cur_pix + 102·prev_pix + 128) >> 8, limited to 255.
- R4: A difference exactly equal to thresh counts as motion: out_pix equals cur_pix.
- R5: A difference greater than thresh counts as motion: out_pix equals cur_pix.
- R6: With thresh equal to 0 every pixel counts as moving and out_pix equals cur_pix.
- R7: When cur_pix equals prev_pix and thresh is non-zero, out_pix equals that pixel value.
- R8: A cycle with in_valid low leaves out_pix unchanged two edges later.
- R9: A blended result always lies between the two input pixels, inclusive, and never exceeds 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The pixel pair and threshold on this cycle are to be processed |
| cur_pix | input | 8 | Sample from the current field |
| prev_pix | input | 8 | Sample at the same position from the previous field |
| thresh | input | 8 | Motion threshold; differences below it are blended |
| out_valid | output | 1 | out_pix carries a new result |
| out_pix | output | 8 | Filtered pixel |

## Verification
The assertions take for granted that cur_pix, prev_pix and thresh are known values whenever in_valid is high, and that the blend weights sum to one fixed-point unit so the rounded sum stays within the pixel range. The stimulus respects this by driving every input from defined values on each cycle, idle cycles included, and by keeping the default weights. Random pixel pairs are mixed with pairs built to land just below, on and just above the threshold, together with the all-zero and all-ones extremes and runs of idle cycles.

// File: rtl/temporal_motion_filter.sv
module temporal_motion_filter #(
  parameter int PIX_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int CUR_WT  = 154,
  parameter int PREV_WT = 102
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] cur_pix,
  input  logic [PIX_W-1:0] prev_pix,
  input  logic [PIX_W-1:0] thresh,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);

  localparam int ACC_W   = PIX_W + FRAC_W + 2;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam int ROUND   = 1 << (FRAC_W - 1);

  logic [PIX_W-1:0] abs_diff;
  logic             still_c;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] scaled;
  logic [PIX_W-1:0] blend_c;

  assign abs_diff = (cur_pix >= prev_pix) ? cur_pix - prev_pix : prev_pix - cur_pix;
  assign still_c  = abs_diff < thresh;
  assign acc      = ACC_W'(CUR_WT) * ACC_W'(cur_pix)
                  + ACC_W'(PREV_WT) * ACC_W'(prev_pix)
                  + ACC_W'(ROUND);
  assign scaled   = acc >> FRAC_W;
  assign blend_c  = (scaled > ACC_W'(PIX_MAX)) ? PIX_W'(PIX_MAX) : scaled[PIX_W-1:0];

  logic             s1_valid;
  logic             s1_still;
  logic [PIX_W-1:0] s1_cur;
  logic [PIX_W-1:0] s1_prev;
  logic [PIX_W-1:0] s1_blend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_still <= 1'b0;
      s1_cur   <= '0;
      s1_prev  <= '0;
      s1_blend <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_still <= still_c;
        s1_cur   <= cur_pix;
        s1_prev  <= prev_pix;
        s1_blend <= blend_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid)
        out_pix <= s1_still ? s1_blend : s1_cur;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  a_r5_motion_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_still) |=> (out_pix == $past(s1_cur)));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_pix));

  a_r9_blend_between: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_still) |=>
      ((out_pix >= $past(s1_cur) || out_pix >= $past(s1_prev)) &&
       (out_pix <= $past(s1_cur) || out_pix <= $past(s1_prev))));

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_pix == '0));

endmodule

// File: tb/test_temporal_motion_filter.sv
module test_temporal_motion_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] cur_pix = '0, prev_pix = '0, thresh = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  temporal_motion_filter i_temporal_motion_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cur_pix(cur_pix), .prev_pix(prev_pix), .thresh(thresh),
    .out_valid(out_valid), .out_pix(out_pix));

  // history of driven inputs: index 1 = one negedge ago, 2 = two ago
  logic       h_v [1:2];
  logic [7:0] h_c [1:2], h_p [1:2], h_t [1:2];
  logic [7:0] model_out = '0;

  function automatic logic [7:0] expect_pix(logic [7:0] c, logic [7:0] p, logic [7:0] t);
    int d, s;
    d = (c >= p) ? int'(c) - int'(p) : int'(p) - int'(c);
    if (d >= int'(t)) return c;
    s = (154 * int'(c) + 102 * int'(p) + 128) / 256;
    if (s > 255) s = 255;
    return 8'(s);
  endfunction

  function automatic string tag_of(logic v, logic [7:0] c, logic [7:0] p, logic [7:0] t);
    int d;
    d = (c >= p) ? int'(c) - int'(p) : int'(p) - int'(c);
    if (!v) return "R8";
    if (t == 0) return "R6";
    if (d == int'(t)) return "R4";
    if (d > int'(t)) return "R5";
    if (c == p) return "R7";
    return "R3";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [7:0] c, logic [7:0] p, logic [7:0] t);
    @(negedge clk);
    check("R2", int'(out_valid), int'(h_v[2]));
    if (h_v[2]) begin
      model_out = expect_pix(h_c[2], h_p[2], h_t[2]);
      check(tag_of(1'b1, h_c[2], h_p[2], h_t[2]), int'(out_pix), int'(model_out));
      if (expect_pix(h_c[2], h_p[2], h_t[2]) != h_c[2] || tag_of(1'b1, h_c[2], h_p[2], h_t[2]) == "R3") begin
        // R9: blended value bounded by the two inputs
        check("R9", int'((out_pix >= h_c[2] || out_pix >= h_p[2]) && (out_pix <= h_c[2] || out_pix <= h_p[2])), 1);
      end
    end else begin
      check("R8", int'(out_pix), int'(model_out));
    end
    h_v[2] = h_v[1]; h_c[2] = h_c[1]; h_p[2] = h_p[1]; h_t[2] = h_t[1];
    h_v[1] = v; h_c[1] = c; h_p[1] = p; h_t[1] = t;
    in_valid = v; cur_pix = c; prev_pix = p; thresh = t;
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 1; i <= 2; i++) begin
      h_v[i] = 1'b0; h_c[i] = '0; h_p[i] = '0; h_t[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_pix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // first cycle after reset release (one edge with rst_n high)
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_pix), 0);

    step(1, 8'd100, 8'd90,  8'd10);  // R4 equal -> motion
    step(1, 8'd100, 8'd91,  8'd10);  // R3 just below
    step(1, 8'd100, 8'd89,  8'd10);  // R5 above
    step(1, 8'd50,  8'd50,  8'd0);   // R6
    step(1, 8'd77,  8'd77,  8'd1);   // R7
    step(1, 8'd255, 8'd255, 8'd255); // R7 / R9 top
    step(1, 8'd0,   8'd0,   8'd255); // R7 bottom
    step(1, 8'd0,   8'd254, 8'd255); // R3 wide blend
    step(1, 8'd255, 8'd0,   8'd255); // R4 diff 255
    step(0, 8'd3,   8'd200, 8'd255); // R8 idle
    step(0, 8'd9,   8'd9,   8'd9);
    step(1, 8'd10,  8'd200, 8'd0);
    step(0, 8'd0,   8'd0,   8'd0);
    step(0, 8'd0,   8'd0,   8'd0);

    for (int n = 0; n < 3000; n++) begin
      logic v;
      logic [7:0] c, p, t;
      v = ($urandom % 4) != 0;
      c = 8'($urandom);
      case ($urandom % 4)
        0: p = 8'($urandom);
        1: p = c;
        default: p = 8'(int'(c) + int'($urandom % 9) - 4);
      endcase
      case ($urandom % 3)
        0: t = 8'($urandom);
        1: t = (c >= p) ? c - p : p - c;
        default: t = 8'($urandom % 16);
      endcase
      step(v, c, p, t);
    end
    step(0, 8'd0, 8'd0, 8'd0);
    step(0, 8'd0, 8'd0, 8'd0);
    step(0, 8'd0, 8'd0, 8'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule